// File: doc/BRIEF.md
# Masked-Page Paired-Frame TLB

A small, fully associative translation buffer. Software picks the slot for each entry it installs. A lookup presents a virtual address and the current address-space identifier. In the same cycle the block reports:
- whether an entry matches, and the slot of that entry;
- the stored tag fields of the matching entry;
- both packed frame halves of the matching entry;
- the physical frame and its attributes for the half that the address selects.

A miss returns an all-ones slot number, which plays the role of minus one for a probe.

Each entry carries a virtual page-pair number and a page mask. The mask widens the page by removing low tag bits from the compare. An entry also holds an address-space identifier and a global bit that waives the identifier check. It maps an even and an odd frame, and each frame has its own cacheable, dirty and valid bits. The address bit just above the masked page offset chooses between the two frames. A flush input empties the table in one cycle. A separate combinational output flags addresses that fall into the uncacheable window.

Top module: `pair_tlb`

## Requirements
- R1: A slot matches only where the lookup tag (address bits VA_W-1 down to PAGE_LSB+1) equals the stored tag on every bit whose stored mask bit is 0. Tag bits under a mask bit of 1 are ignored, and mask bit i covers tag bit i.
- R2: A match also needs the stored global bit set, or the stored identifier equal to `lk_asid`.
- R3: On a hit, `hit` is 1 and `hit_idx` gives the slot. On a miss, `hit` is 0, `hit_idx` is all ones and the readout fields are zero.
- R4: When several slots match, the lowest slot number is reported.
- R5: A write with `wr_en` and an in-range `wr_idx` replaces the slot at the next rising edge. A lookup in the same cycle sees the old contents, and the old tag no longer matches from the next cycle on.
- R6: A write with `wr_idx` not below ENTRIES changes no slot.
- R7: `flush` clears every slot at the next edge, and no lookup hits afterwards. Flush takes priority over a write in the same cycle.
- R8: A slot whose two valid bits are both 0 never matches.
- R9: `uncached` is 1 exactly when address bits 31 and 29 of `lk_va` are both 1.
- R10: The frame half is chosen by `lk_va` bit PAGE_LSB+n, where n is the count of ones in the matching slot's mask. A value of 0 selects the even frame and 1 selects the odd frame. `hit_pfn`, `hit_valid`, `hit_dirty` and `hit_cache` come from that half.
- R11: Each packed half word holds the frame number from bit 6 upward, bits 5:4 zero, the cacheable bit at bit 3, dirty at bit 2, valid at bit 1 and the global bit at bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Clear all slots |
| wr_en | input | 1 | Install an entry |
| wr_idx | input | IDX_W+1 | Target slot, out-of-range values ignored |
| wr_vpn | input | VPN_W | Page-pair tag |
| wr_mask | input | MASK_W | Page mask, 1 ignores a tag bit |
| wr_asid | input | ASID_W | Address-space identifier |
| wr_g | input | 1 | Global bit |
| wr_pfn0 | input | PFN_W | Even frame number |
| wr_c0 | input | 1 | Even cacheable |
| wr_d0 | input | 1 | Even dirty |
| wr_v0 | input | 1 | Even valid |
| wr_pfn1 | input | PFN_W | Odd frame number |
| wr_c1 | input | 1 | Odd cacheable |
| wr_d1 | input | 1 | Odd dirty |
| wr_v1 | input | 1 | Odd valid |
| lk_va | input | VA_W | Lookup virtual address |
| lk_asid | input | ASID_W | Current identifier |
| hit | output | 1 | A slot matches |
| hit_idx | output | IDX_W | Matching slot, all ones on miss |
| hit_pfn | output | PFN_W | Frame of the selected half |
| hit_valid | output | 1 | Valid bit of the selected half |
| hit_dirty | output | 1 | Dirty bit of the selected half |
| hit_cache | output | 1 | Cacheable bit of the selected half |
| rd_vpn | output | VPN_W | Stored tag of the matching slot |
| rd_mask | output | MASK_W | Stored mask of the matching slot |
| rd_asid | output | ASID_W | Stored identifier of the matching slot |
| rd_even | output | PFN_W+6 | Packed even half |
| rd_odd | output | PFN_W+6 | Packed odd half |
| uncached | output | 1 | Address lies in the uncacheable window |

## Verification
The hardest case to reach from the ports is a lookup that races an install to the same slot. It must still see the old entry before the edge and the new one after it. The bench drives the write fields and a matching lookup in the same low phase, checks for a miss before the rising edge, and then checks for a hit after it. Priority is reached by loading two slots with the same tag and then rewriting the lower slot, which exposes the higher one. A second out-of-range write aims at a live tag with different frames, so any leakage shows up as a changed frame.

// File: rtl/pair_tlb.sv
module pair_tlb #(
  parameter int ENTRIES  = 8,
  parameter int VA_W     = 32,
  parameter int PAGE_LSB = 12,
  parameter int MASK_W   = 8,
  parameter int ASID_W   = 8,
  parameter int PFN_W    = 20,
  localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int WIDX_W  = IDX_W + 1,
  localparam int VPN_W   = VA_W - PAGE_LSB - 1,
  localparam int HW_W    = PFN_W + 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              wr_en,
  input  logic [WIDX_W-1:0] wr_idx,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [MASK_W-1:0] wr_mask,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic              wr_g,
  input  logic [PFN_W-1:0]  wr_pfn0,
  input  logic              wr_c0,
  input  logic              wr_d0,
  input  logic              wr_v0,
  input  logic [PFN_W-1:0]  wr_pfn1,
  input  logic              wr_c1,
  input  logic              wr_d1,
  input  logic              wr_v1,
  input  logic [VA_W-1:0]   lk_va,
  input  logic [ASID_W-1:0] lk_asid,
  output logic              hit,
  output logic [IDX_W-1:0]  hit_idx,
  output logic [PFN_W-1:0]  hit_pfn,
  output logic              hit_valid,
  output logic              hit_dirty,
  output logic              hit_cache,
  output logic [VPN_W-1:0]  rd_vpn,
  output logic [MASK_W-1:0] rd_mask,
  output logic [ASID_W-1:0] rd_asid,
  output logic [HW_W-1:0]   rd_even,
  output logic [HW_W-1:0]   rd_odd,
  output logic              uncached
);
  localparam logic [VA_W-1:0] UNC_WIN = VA_W'(32'hA000_0000);

  logic [ENTRIES-1:0][VPN_W-1:0]  vpn_q;
  logic [ENTRIES-1:0][MASK_W-1:0] mask_q;
  logic [ENTRIES-1:0][ASID_W-1:0] asid_q;
  logic [ENTRIES-1:0][PFN_W-1:0]  pfn0_q, pfn1_q;
  logic [ENTRIES-1:0]             g_q, c0_q, d0_q, v0_q, c1_q, d1_q, v1_q;

  logic              wr_ok;
  logic [IDX_W-1:0]  wi;
  assign wr_ok = wr_en && (wr_idx < WIDX_W'(ENTRIES));
  assign wi    = wr_idx[IDX_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || flush) begin
      vpn_q <= '0; mask_q <= '0; asid_q <= '0; pfn0_q <= '0; pfn1_q <= '0;
      g_q <= '0; c0_q <= '0; d0_q <= '0; v0_q <= '0; c1_q <= '0; d1_q <= '0; v1_q <= '0;
    end else if (wr_ok) begin
      vpn_q[wi]  <= wr_vpn;  mask_q[wi] <= wr_mask; asid_q[wi] <= wr_asid;
      g_q[wi]    <= wr_g;
      pfn0_q[wi] <= wr_pfn0; c0_q[wi] <= wr_c0; d0_q[wi] <= wr_d0; v0_q[wi] <= wr_v0;
      pfn1_q[wi] <= wr_pfn1; c1_q[wi] <= wr_c1; d1_q[wi] <= wr_d1; v1_q[wi] <= wr_v1;
    end
  end

  logic [VPN_W-1:0]   lk_vpn;
  logic [ENTRIES-1:0] match;
  assign lk_vpn = lk_va[VA_W-1:PAGE_LSB+1];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    logic [VPN_W-1:0] care;
    assign care     = ~{{(VPN_W-MASK_W){1'b0}}, mask_q[e]};
    assign match[e] = (v0_q[e] | v1_q[e])
                    && (((lk_vpn ^ vpn_q[e]) & care) == '0)
                    && (g_q[e] || (asid_q[e] == lk_asid));
  end

  logic [IDX_W-1:0] sel;
  logic             any;
  always_comb begin
    sel = '1;
    any = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (match[i]) begin
        sel = IDX_W'(i);
        any = 1'b1;
      end
  end

  logic [VPN_W-1:0]  s_vpn;
  logic [MASK_W-1:0] s_mask;
  logic [ASID_W-1:0] s_asid;
  logic [PFN_W-1:0]  s_pfn0, s_pfn1;
  logic              s_g, s_c0, s_d0, s_v0, s_c1, s_d1, s_v1;
  always_comb begin
    {s_vpn, s_mask, s_asid, s_pfn0, s_pfn1} = '0;
    {s_g, s_c0, s_d0, s_v0, s_c1, s_d1, s_v1} = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (any && sel == IDX_W'(i)) begin
        s_vpn = vpn_q[i]; s_mask = mask_q[i]; s_asid = asid_q[i]; s_g = g_q[i];
        s_pfn0 = pfn0_q[i]; s_c0 = c0_q[i]; s_d0 = d0_q[i]; s_v0 = v0_q[i];
        s_pfn1 = pfn1_q[i]; s_c1 = c1_q[i]; s_d1 = d1_q[i]; s_v1 = v1_q[i];
      end
  end

  logic [VA_W-1:0] shifted;
  logic            odd;
  assign shifted = lk_va >> (PAGE_LSB + $countones(s_mask));
  assign odd     = shifted[0];

  assign hit       = any;
  assign hit_idx   = sel;
  assign rd_vpn    = s_vpn;
  assign rd_mask   = s_mask;
  assign rd_asid   = s_asid;
  assign rd_even   = {s_pfn0, 2'b00, s_c0, s_d0, s_v0, s_g};
  assign rd_odd    = {s_pfn1, 2'b00, s_c1, s_d1, s_v1, s_g};
  assign hit_pfn   = odd ? s_pfn1 : s_pfn0;
  assign hit_valid = odd ? s_v1 : s_v0;
  assign hit_dirty = odd ? s_d1 : s_d0;
  assign hit_cache = odd ? s_c1 : s_c0;
  assign uncached  = (lk_va & UNC_WIN) == UNC_WIN;

  p_hit_tag_r1: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (((lk_vpn ^ rd_vpn) & ~{{(VPN_W-MASK_W){1'b0}}, rd_mask}) == '0));
  p_hit_asid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (rd_even[0] || rd_asid == lk_asid));
  p_hit_occupied_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (rd_even[1] || rd_odd[1]));
  p_flush_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !hit);
  p_write_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !flush && wr_idx < WIDX_W'(ENTRIES))
      |=> (v0_q[$past(wi)] == $past(wr_v0) && vpn_q[$past(wi)] == $past(wr_vpn)));
  p_oob_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !flush && wr_idx >= WIDX_W'(ENTRIES))
      |=> ($stable(vpn_q) && $stable(v0_q) && $stable(v1_q) && $stable(pfn0_q) && $stable(pfn1_q)));
endmodule

// File: tb/pair_tlb_tb.sv
module pair_tlb_tb;
  logic clk = 0, rst_n = 0, flush = 0, wr_en = 0;
  logic [3:0] wr_idx = '0;
  logic [18:0] wr_vpn = '0;
  logic [7:0] wr_mask = '0, wr_asid = '0, lk_asid = '0;
  logic wr_g = 0, wr_c0 = 0, wr_d0 = 0, wr_v0 = 0, wr_c1 = 0, wr_d1 = 0, wr_v1 = 0;
  logic [19:0] wr_pfn0 = '0, wr_pfn1 = '0;
  logic [31:0] lk_va = '0;
  logic hit, hit_valid, hit_dirty, hit_cache, uncached;
  logic [2:0] hit_idx;
  logic [19:0] hit_pfn;
  logic [18:0] rd_vpn;
  logic [7:0] rd_mask, rd_asid;
  logic [25:0] rd_even, rd_odd;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  pair_tlb u_dut (.clk, .rst_n, .flush, .wr_en, .wr_idx, .wr_vpn, .wr_mask, .wr_asid, .wr_g,
    .wr_pfn0, .wr_c0, .wr_d0, .wr_v0, .wr_pfn1, .wr_c1, .wr_d1, .wr_v1, .lk_va, .lk_asid,
    .hit, .hit_idx, .hit_pfn, .hit_valid, .hit_dirty, .hit_cache, .rd_vpn, .rd_mask,
    .rd_asid, .rd_even, .rd_odd, .uncached);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic put(int idx, logic [18:0] vpn, logic [7:0] m, logic [7:0] asid, logic g,
                     logic [19:0] p0, logic [2:0] cdv0, logic [19:0] p1, logic [2:0] cdv1);
    @(negedge clk);
    wr_en = 1; wr_idx = 4'(idx); wr_vpn = vpn; wr_mask = m; wr_asid = asid; wr_g = g;
    wr_pfn0 = p0; {wr_c0, wr_d0, wr_v0} = cdv0; wr_pfn1 = p1; {wr_c1, wr_d1, wr_v1} = cdv1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic look(logic [31:0] va, logic [7:0] asid);
    lk_va = va; lk_asid = asid;
    #1;
  endtask

  function automatic logic [31:0] va_of(logic [18:0] vpn, logic odd12);
    return {vpn, odd12, 12'h0};
  endfunction

  task automatic t_reset;
    look(32'h0, 8'h0);
    chk("R3 reset hit", hit, 0);
    chk("R3 reset idx", hit_idx, 3'h7);
    chk("R3 reset readout", rd_even, 0);
  endtask

  task automatic t_basic;
    put(2, 19'h00123, 8'h00, 8'h05, 0, 20'h11, 3'b101, 20'h22, 3'b011);
    look(va_of(19'h00123, 0), 8'h05);
    chk("R3 hit", hit, 1);
    chk("R3 idx", hit_idx, 2);
    chk("R10 even pfn", hit_pfn, 20'h11);
    chk("R10 even attrs", {hit_cache, hit_dirty, hit_valid}, 3'b101);
    chk("R11 even word", rd_even, 26'h44A);
    chk("R11 odd word", rd_odd, 26'h886);
    chk("R3 tag readout", {rd_vpn, rd_asid}, {19'h00123, 8'h05});
    look(va_of(19'h00123, 1), 8'h05);
    chk("R10 odd pfn", hit_pfn, 20'h22);
    chk("R10 odd attrs", {hit_cache, hit_dirty, hit_valid}, 3'b011);
  endtask

  task automatic t_asid;
    look(va_of(19'h00123, 0), 8'h06);
    chk("R2 asid mismatch hit", hit, 0);
    chk("R3 miss idx", hit_idx, 3'h7);
    put(4, 19'h00200, 8'h00, 8'h01, 1, 20'h33, 3'b001, 20'h44, 3'b000);
    look(va_of(19'h00200, 0), 8'h09);
    chk("R2 global hit", {hit, hit_idx}, {1'b1, 3'd4});
    chk("R11 global bit", rd_even[0], 1);
    look(va_of(19'h00200, 1), 8'h09);
    chk("R10 odd half invalid", {hit, hit_valid, hit_pfn}, {1'b1, 1'b0, 20'h44});
  endtask

  task automatic t_mask;
    put(5, 19'h00300, 8'h03, 8'h02, 0, 20'h55, 3'b001, 20'h66, 3'b001);
    look(va_of(19'h00303, 0), 8'h02);
    chk("R1 masked bits ignored", {hit, hit_idx}, {1'b1, 3'd5});
    look(va_of(19'h00304, 0), 8'h02);
    chk("R1 unmasked bit compared", hit, 0);
    look(va_of(19'h00301, 1), 8'h02);
    chk("R10 masked select even", hit_pfn, 20'h55);
    look(va_of(19'h00302, 0), 8'h02);
    chk("R10 masked select odd", hit_pfn, 20'h66);
  endtask

  task automatic t_priority;
    put(6, 19'h00400, 8'h00, 8'h03, 0, 20'h77, 3'b001, 20'h0, 3'b000);
    put(1, 19'h00400, 8'h00, 8'h03, 0, 20'h88, 3'b001, 20'h0, 3'b000);
    look(va_of(19'h00400, 0), 8'h03);
    chk("R4 lowest index", {hit_idx, hit_pfn}, {3'd1, 20'h88});
    put(1, 19'h00401, 8'h00, 8'h03, 0, 20'h99, 3'b001, 20'h0, 3'b000);
    look(va_of(19'h00400, 0), 8'h03);
    chk("R5 replaced tag gone", {hit_idx, hit_pfn}, {3'd6, 20'h77});
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    wr_en = 1; wr_idx = 0; wr_vpn = 19'h00500; wr_mask = 0; wr_asid = 8'h07; wr_g = 0;
    wr_pfn0 = 20'hAB; {wr_c0, wr_d0, wr_v0} = 3'b001; wr_pfn1 = 0; {wr_c1, wr_d1, wr_v1} = 0;
    look(va_of(19'h00500, 0), 8'h07);
    chk("R5 old contents before edge", hit, 0);
    @(negedge clk);
    wr_en = 0;
    #1;
    chk("R5 new entry after edge", {hit, hit_idx, hit_pfn}, {1'b1, 3'd0, 20'hAB});
  endtask

  task automatic t_oob;
    put(8, 19'h00600, 8'h00, 8'h00, 1, 20'h1, 3'b001, 20'h1, 3'b001);
    look(va_of(19'h00600, 0), 8'h00);
    chk("R6 out-of-range write ignored", hit, 0);
    put(9, 19'h00123, 8'h00, 8'h05, 0, 20'hEE, 3'b001, 20'hEE, 3'b001);
    look(va_of(19'h00123, 0), 8'h05);
    chk("R6 existing slot intact", {hit_idx, hit_pfn}, {3'd2, 20'h11});
  endtask

  task automatic t_occupancy;
    put(3, 19'h00700, 8'h00, 8'h00, 1, 20'h5, 3'b110, 20'h6, 3'b110);
    look(va_of(19'h00700, 0), 8'h00);
    chk("R8 no valid half no match", hit, 0);
  endtask

  task automatic t_uncached;
    look(32'hA000_0000, 0); chk("R9 window base", uncached, 1);
    look(32'hBFFF_FFFF, 0); chk("R9 window top", uncached, 1);
    look(32'hE000_1234, 0); chk("R9 extra bits set", uncached, 1);
    look(32'h8000_0000, 0); chk("R9 bit29 clear", uncached, 0);
    look(32'h2000_0000, 0); chk("R9 bit31 clear", uncached, 0);
  endtask

  task automatic t_flush;
    @(negedge clk);
    flush = 1;
    wr_en = 1; wr_idx = 7; wr_vpn = 19'h00800; wr_mask = 0; wr_asid = 0; wr_g = 1;
    {wr_c0, wr_d0, wr_v0} = 3'b001;
    @(negedge clk);
    flush = 0; wr_en = 0;
    look(va_of(19'h00123, 0), 8'h05); chk("R7 flushed slot 2", hit, 0);
    look(va_of(19'h00200, 0), 8'h01); chk("R7 flushed global", hit, 0);
    look(va_of(19'h00800, 0), 8'h00); chk("R7 flush beats write", hit, 0);
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_basic;
    t_asid;
    t_mask;
    t_priority;
    t_same_cycle;
    t_oob;
    t_occupancy;
    t_uncached;
    t_flush;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule